// File: doc/BRIEF.md
# ECC Protected Memory Access Controller

This block sits between a bus master and a data RAM that is 64 bits wide and keeps 8 check bits beside every doubleword. The master issues byte, halfword, word or doubleword requests on a simple valid/ready port. The controller fetches the whole doubleword for every request and runs it through an extended Hamming decoder, which has 7 position bits and one overall parity bit. A single flipped bit is repaired in the data on its way out, and nothing records that it happened. Two flipped bits cannot be repaired. They raise a one-cycle interrupt and load a small capture register set that holds the failing address, the access size and the direction.

A write merges the new bytes into the fetched doubleword, encodes fresh check bits and stores all 72 bits. A narrow write that finds an uncorrectable word in its read phase stores nothing, so damaged bytes are never sealed under valid check bits. A full doubleword write replaces every byte, so it always stores. Checking can be switched off with an input. While it is off, the encoder still runs, so memory can be filled before checking is turned on. A test input XORs a chosen mask into the 72 bits on their way into the RAM.

Top module: `ecc_mem_ctrl`

## Requirements
- R1: After reset the outputs are `req_ready`=1, `rsp_valid`=0, `irq`=0 and `cap_valid`=0.
- R2: For a read accepted at a clock edge, `rsp_valid` is high for exactly one cycle after the second edge that follows. `req_ready` is low from the edge after acceptance until the response.
- R3: For a write accepted at a clock edge, `rsp_valid` is high for one cycle after the third edge that follows. A later read returns the written data.
- R4: Reading a doubleword that has no error returns the stored 64 bits with `rsp_err`=0.
- R5: The stored codeword is laid out as bits 63:0 data, bits 70:64 Hamming bits and bit 71 overall parity, and `inj_flip` uses the same bit numbering. With checking on, a single flipped bit anywhere in the codeword returns the correct data with `rsp_err`=0, no `irq` and no capture.
- R6: With checking on, any two flipped bits give `rsp_err`=1 on the response. They also give an `irq` pulse of one cycle after the second edge following acceptance, for reads and writes alike.
- R7: Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. The offset is rounded down to a multiple of the size. Byte lane k is bits 8k+7:8k of `req_wdata`. Only the addressed lanes change, and the other bytes keep their corrected old values.
- R8: A narrow write to a word with one flipped bit stores the corrected bytes together with fresh check bits, so the raw stored data afterwards holds no flipped bit.
- R9: A narrow write whose read phase finds an uncorrectable error leaves the memory word unchanged.
- R10: A doubleword write is stored even when its read phase finds an uncorrectable error, and a later read of that word is clean.
- R11: With `chk_en`=0, reads return the raw stored data with no correction, no `rsp_err`, no `irq` and no capture. Writes still store valid check bits, so reads are clean once checking is turned on.
- R12: An uncorrectable error while `cap_valid`=0 sets `cap_valid` and records the doubleword address, size code and direction (`cap_write`=1 for a write), after the second edge following acceptance.
- R13: While `cap_valid`=1, later errors leave the capture unchanged. A `cap_clr` pulse clears `cap_valid` at the next edge. If an error arrives in the same cycle as `cap_clr`, that error is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_en | input | 1 | Enables checking and correction |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle, request accepted when valid |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Doubleword address |
| req_size | input | 2 | Size code: 0 byte, 1 halfword, 2 word, 3 doubleword |
| req_offset | input | 3 | Byte offset inside the doubleword |
| req_wdata | input | 64 | Write data placed in its byte lanes |
| inj_flip | input | 72 | Bits flipped in the stored codeword, sampled with the request |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 64 | Corrected (or raw) doubleword for reads |
| rsp_err | output | 1 | Uncorrectable error seen by this access |
| irq | output | 1 | One-cycle interrupt on an uncorrectable error |
| cap_clr | input | 1 | Clears the capture |
| cap_valid | output | 1 | Capture holds an error |
| cap_addr | output | ADDR_W | Captured doubleword address |
| cap_size | output | 2 | Captured size code |
| cap_write | output | 1 | Captured direction |

## Verification
A read's data and error flag appear after the second rising edge that follows acceptance. The interrupt and the capture registers of any access also update after that edge. A write's response appears one edge later, and its data is in memory at that point. The bench drives requests on falling edges and steps edge by edge from the accept edge. It samples `req_ready` and `rsp_valid` at each falling edge in between, and it takes data, error, interrupt and capture values at the falling edge just after the edge on which each is due. A capture clear that must coincide with an error is driven high only across that same second edge.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_CHECK,
    ST_WBACK
  } ctrl_state_t;

  // Number of Hamming position bits needed to cover dw data bits.
  function automatic int ham_width(int dw);
    int r;
    r = 0;
    for (int k = 1; k < 16; k++) begin
      if (r == 0 && (1 << k) >= dw + k + 1) r = k;
    end
    return r;
  endfunction

  // Codeword position (1-based, skipping powers of two) of data bit idx.
  function automatic int data_pos(int idx);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int p = 1; p < idx + 72; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == idx) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
  import ecc_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int HAM_W  = 7
)(
  input  logic [DATA_W-1:0] data,
  output logic [HAM_W-1:0]  ham,
  output logic              par
);

  function automatic logic [DATA_W-1:0] mask_of(int b);
    logic [DATA_W-1:0] m;
    for (int j = 0; j < DATA_W; j++) m[j] = ((data_pos(j) >> b) & 1) != 0;
    return m;
  endfunction

  for (genvar i = 0; i < HAM_W; i++) begin : g_ham
    localparam logic [DATA_W-1:0] MASK = mask_of(i);
    assign ham[i] = ^(data & MASK);
  end

  // overall parity makes the XOR of all stored bits zero
  assign par = ^{ham, data};

endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder
  import ecc_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int HAM_W  = 7,
  localparam int CW_W   = DATA_W + HAM_W + 1,
  localparam int MAXPOS = DATA_W + HAM_W
)(
  input  logic [CW_W-1:0]   code,
  output logic [DATA_W-1:0] data_o,
  output logic              uncorr
);

  logic [HAM_W-1:0] calc_ham;
  logic [HAM_W-1:0] syn;
  logic             calc_par;
  logic             par_bad;

  ecc_encoder #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_recalc (
    .data (code[DATA_W-1:0]),
    .ham  (calc_ham),
    .par  (calc_par)
  );

  assign syn     = code[DATA_W +: HAM_W] ^ calc_ham;
  assign par_bad = calc_par ^ (^syn) ^ code[CW_W-1];

  // odd parity: one flip at position syn (0 = the parity bit itself)
  for (genvar j = 0; j < DATA_W; j++) begin : g_fix
    localparam int POS = data_pos(j);
    assign data_o[j] = code[j] ^ (par_bad && (syn == HAM_W'(POS)));
  end

  assign uncorr = (!par_bad && (syn != '0)) ||
                  (par_bad && (syn > HAM_W'(MAXPOS)));

endmodule

// File: rtl/ecc_ram.sv
module ecc_ram #(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 72,
  localparam int DEPTH = 2 ** ADDR_W
)(
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture #(
  parameter int ADDR_W = 4
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic              clr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              write,
  output logic              cap_valid,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [1:0]        cap_size,
  output logic              cap_write
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_valid <= 1'b0;
      cap_addr  <= '0;
      cap_size  <= '0;
      cap_write <= 1'b0;
    end else if (hit && (!cap_valid || clr)) begin
      cap_valid <= 1'b1;
      cap_addr  <= addr;
      cap_size  <= size;
      cap_write <= write;
    end else if (clr) begin
      cap_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/ecc_mem_ctrl.sv
module ecc_mem_ctrl
  import ecc_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 4,
  localparam int HAM_W = ham_width(DATA_W),
  localparam int CW_W  = DATA_W + HAM_W + 1,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              chk_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CW_W-1:0]   inj_flip,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              irq,
  input  logic              cap_clr,
  output logic              cap_valid,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [1:0]        cap_size,
  output logic              cap_write
);

  ctrl_state_t       state;
  logic              l_write;
  logic [ADDR_W-1:0] l_addr;
  logic [1:0]        l_size;
  logic [OFF_W-1:0]  l_off;
  logic [DATA_W-1:0] l_wdata;
  logic [CW_W-1:0]   l_inj;

  logic [CW_W-1:0]   ram_q;
  logic [CW_W-1:0]   wb_code;
  logic              wb_en;
  logic              ram_we;

  logic [DATA_W-1:0] dec_data;
  logic              dec_uncorr;
  logic [DATA_W-1:0] eff_data;
  logic              eff_uncorr;
  logic [LANES-1:0]  lane_en;
  logic [DATA_W-1:0] byte_mask;
  logic              full_wr;
  logic [DATA_W-1:0] merged;
  logic [HAM_W-1:0]  enc_ham;
  logic              enc_par;
  logic              accept;
  logic              err_hit;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  // sequencing: fetch, check, optional write-back
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:  if (accept) state <= ST_READ;
        ST_READ:  state <= ST_CHECK;
        ST_CHECK: state <= l_write ? ST_WBACK : ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      l_write <= 1'b0;
      l_addr  <= '0;
      l_size  <= '0;
      l_off   <= '0;
      l_wdata <= '0;
      l_inj   <= '0;
    end else if (accept) begin
      l_write <= req_write;
      l_addr  <= req_addr;
      l_size  <= req_size;
      l_off   <= req_offset;
      l_wdata <= req_wdata;
      l_inj   <= inj_flip;
    end
  end

  // lanes of the aligned group that contains the offset
  always_comb begin
    lane_en   = '0;
    byte_mask = '0;
    for (int k = 0; k < LANES; k++) begin
      lane_en[k] = ((k >> l_size) == (int'(l_off) >> l_size));
      byte_mask[8*k +: 8] = {8{lane_en[k]}};
    end
  end

  assign full_wr = &lane_en;

  ecc_decoder #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_dec (
    .code   (ram_q),
    .data_o (dec_data),
    .uncorr (dec_uncorr)
  );

  assign eff_data   = chk_en ? dec_data : ram_q[DATA_W-1:0];
  assign eff_uncorr = chk_en && dec_uncorr;
  assign merged     = (l_wdata & byte_mask) | (eff_data & ~byte_mask);
  assign err_hit    = (state == ST_CHECK) && eff_uncorr;

  ecc_encoder #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_enc (
    .data (merged),
    .ham  (enc_ham),
    .par  (enc_par)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
      irq       <= 1'b0;
      wb_code   <= '0;
      wb_en     <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      irq       <= err_hit;
      if (state == ST_CHECK) begin
        rsp_rdata <= eff_data;
        rsp_err   <= eff_uncorr;
        rsp_valid <= !l_write;
        wb_code   <= {enc_par, enc_ham, merged} ^ l_inj;
        wb_en     <= !(eff_uncorr && !full_wr);
      end
      if (state == ST_WBACK) rsp_valid <= 1'b1;
    end
  end

  assign ram_we = (state == ST_WBACK) && wb_en;

  ecc_ram #(.ADDR_W(ADDR_W), .WORD_W(CW_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (l_addr),
    .wdata (wb_code),
    .raddr (l_addr),
    .rdata (ram_q)
  );

  ecc_err_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .hit       (err_hit),
    .clr       (cap_clr),
    .addr      (l_addr),
    .size      (l_size),
    .write     (l_write),
    .cap_valid (cap_valid),
    .cap_addr  (cap_addr),
    .cap_size  (cap_size),
    .cap_write (cap_write)
  );

endmodule

// File: rtl/ecc_mem_ctrl_chk.sv
module ecc_mem_ctrl_chk #(
  parameter int ADDR_W = 4
)(
  input logic              clk,
  input logic              rst,
  input logic              chk_en,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              irq,
  input logic              cap_clr,
  input logic              cap_valid,
  input logic [ADDR_W-1:0] cap_addr
);

  // R2
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R6
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R11
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(chk_en));

  // R12
  capture_with_irq_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cap_valid) |-> irq);

  // R13
  capture_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_valid && !cap_clr) |=> (cap_valid && $stable(cap_addr)));

endmodule

bind ecc_mem_ctrl ecc_mem_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .chk_en    (chk_en),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .irq       (irq),
  .cap_clr   (cap_clr),
  .cap_valid (cap_valid),
  .cap_addr  (cap_addr)
);

// File: tb/ecc_mem_ctrl_bench.sv
module ecc_mem_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 64;
  localparam int AW         = 4;
  localparam int CW         = 72;
  localparam int WD_CYCLES  = 150000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          chk_en = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = '0;
  logic [2:0]    req_offset = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [CW-1:0] inj_flip = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          rsp_err;
  logic          irq;
  logic          cap_clr = 1'b0;
  logic          cap_valid;
  logic [AW-1:0] cap_addr;
  logic [1:0]    cap_size;
  logic          cap_write;

  int            check_cnt = 0;
  int            fail_cnt  = 0;
  bit            done = 1'b0;

  logic [DW-1:0] rd_q;
  logic          err_q;
  logic          irq_q;
  logic          lat_q;
  logic [DW-1:0] model [16];
  logic [DW-1:0] exp_d;

  ecc_mem_ctrl #(.DATA_W(DW), .ADDR_W(AW)) u_ecc_mem_ctrl (
    .clk(clk), .rst(rst), .chk_en(chk_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_offset(req_offset),
    .req_wdata(req_wdata), .inj_flip(inj_flip),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .irq(irq), .cap_clr(cap_clr), .cap_valid(cap_valid),
    .cap_addr(cap_addr), .cap_size(cap_size), .cap_write(cap_write)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] pat(int s);
    return {32'(s) * 32'h9E3779B9, ~(32'(s) * 32'h85EBCA6B)};
  endfunction

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] wd, int sz, int off);
    int nb;
    int base;
    logic [DW-1:0] r;
    nb   = 1 << sz;
    base = off - (off % nb);
    r    = old;
    for (int b = 0; b < 8; b++)
      if (b >= base && b < base + nb) r[8*b +: 8] = wd[8*b +: 8];
    return r;
  endfunction

  function automatic logic [CW-1:0] bitm(int k);
    return CW'(1) << k;
  endfunction

  task automatic check_eq(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    check_cnt++;
    if (act !== exp) begin
      fail_cnt++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // one request; results left in rd_q, err_q, irq_q, lat_q
  task automatic access(input bit wr, input int addr, input int sz, input int off,
                        input logic [DW-1:0] wd, input logic [CW-1:0] inj, input bit clr_mid);
    @(negedge clk);
    req_valid  = 1'b1;
    req_write  = wr;
    req_addr   = AW'(addr);
    req_size   = 2'(sz);
    req_offset = 3'(off);
    req_wdata  = wd;
    inj_flip   = inj;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    inj_flip  = '0;
    lat_q = !req_ready && !rsp_valid;
    @(posedge clk);
    @(negedge clk);
    lat_q = lat_q && !rsp_valid;
    if (clr_mid) cap_clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cap_clr = 1'b0;
    irq_q = irq;
    if (wr) begin
      lat_q = lat_q && !rsp_valid;
      @(posedge clk);
      @(negedge clk);
    end
    lat_q = lat_q && rsp_valid;
    rd_q  = rsp_rdata;
    err_q = rsp_err;
  endtask

  task automatic clear_cap();
    @(negedge clk);
    cap_clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cap_clr = 1'b0;
    check_eq("R13 clear drops cap_valid", CW'(cap_valid), CW'(0));
  endtask

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      check_cnt++;
      fail_cnt++;
      $display("FAIL R2 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", check_cnt, fail_cnt);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1
    check_eq("R1 req_ready", CW'(req_ready), CW'(1));
    check_eq("R1 rsp_valid", CW'(rsp_valid), CW'(0));
    check_eq("R1 irq", CW'(irq), CW'(0));
    check_eq("R1 cap_valid", CW'(cap_valid), CW'(0));

    // R11: fill memory with checking off, then read with checking on
    chk_en = 1'b0;
    for (int a = 0; a < 16; a++) begin
      model[a] = pat(a + 1);
      access(1'b1, a, 3, 0, model[a], '0, 1'b0);
      check_eq("R3 write latency", CW'(lat_q), CW'(1));
    end
    chk_en = 1'b1;
    for (int a = 0; a < 16; a++) begin
      access(1'b0, a, 3, 0, '0, '0, 1'b0);
      check_eq("R2 read latency", CW'(lat_q), CW'(1));
      check_eq("R4 R11 clean data", CW'(rd_q), CW'(model[a]));
      check_eq("R4 clean err", CW'(err_q), CW'(0));
    end

    // R5: every single-bit flip
    for (int k = 0; k < CW; k++) begin
      exp_d = pat(500 + k);
      access(1'b1, 3, 3, 0, exp_d, bitm(k), 1'b0);
      check_eq("R5 write no irq", CW'(irq_q), CW'(0));
      access(1'b0, 3, 3, 0, '0, '0, 1'b0);
      check_eq("R5 corrected data", CW'(rd_q), CW'(exp_d));
      check_eq("R5 no err", CW'({err_q, irq_q}), CW'(0));
    end
    check_eq("R5 no capture", CW'(cap_valid), CW'(0));

    // R6: every pair of flips
    for (int i = 0; i < CW; i++) begin
      for (int j = i + 1; j < CW; j++) begin
        access(1'b1, 5, 3, 0, pat(i * CW + j), bitm(i) | bitm(j), 1'b0);
        access(1'b0, 5, 3, 0, '0, '0, 1'b0);
        check_eq("R6 double err", CW'({err_q, irq_q}), CW'(3));
      end
    end
    // R12 first error captured, R13 later ones ignored
    check_eq("R12 cap_valid", CW'(cap_valid), CW'(1));
    check_eq("R12 R13 cap_addr", CW'(cap_addr), CW'(5));
    check_eq("R12 cap_size", CW'(cap_size), CW'(3));
    check_eq("R12 R13 cap_write", CW'(cap_write), CW'(0));
    clear_cap();

    // R10: full write over an uncorrectable word
    exp_d = pat(777);
    access(1'b1, 5, 3, 0, exp_d, '0, 1'b0);
    check_eq("R10 write sees err", CW'({err_q, irq_q}), CW'(3));
    check_eq("R12 cap_write", CW'({cap_valid, cap_write}), CW'(3));
    access(1'b0, 5, 3, 0, '0, '0, 1'b0);
    check_eq("R10 data stored", CW'(rd_q), CW'(exp_d));
    check_eq("R10 clean after", CW'(err_q), CW'(0));
    model[5] = exp_d;

    // R13: clear in the same cycle as a new error
    access(1'b1, 7, 3, 0, pat(70), bitm(2) | bitm(66), 1'b0);
    access(1'b0, 7, 1, 2, '0, '0, 1'b1);
    check_eq("R13 clear+error valid", CW'(cap_valid), CW'(1));
    check_eq("R13 clear+error addr", CW'(cap_addr), CW'(7));
    check_eq("R13 clear+error size", CW'(cap_size), CW'(1));
    clear_cap();

    // R7: all sizes and offsets
    for (int sz = 0; sz < 4; sz++) begin
      for (int off = 0; off < 8; off++) begin
        exp_d = pat(100 + sz * 8 + off);
        model[9] = merge(model[9], exp_d, sz, off);
        access(1'b1, 9, sz, off, exp_d, '0, 1'b0);
        access(1'b0, 9, 3, 0, '0, '0, 1'b0);
        check_eq("R7 merged data", CW'(rd_q), CW'(model[9]));
      end
    end

    // R8: narrow write scrubs a single flip
    model[10] = pat(1010);
    access(1'b1, 10, 3, 0, model[10], bitm(20), 1'b0);
    access(1'b1, 10, 0, 0, 64'hA5, '0, 1'b0);
    check_eq("R8 write no err", CW'({err_q, irq_q}), CW'(0));
    model[10] = merge(model[10], 64'hA5, 0, 0);
    chk_en = 1'b0;
    access(1'b0, 10, 3, 0, '0, '0, 1'b0);
    check_eq("R8 raw scrubbed", CW'(rd_q), CW'(model[10]));
    chk_en = 1'b1;

    // R9: narrow write aborted on uncorrectable read
    model[11] = pat(1111);
    access(1'b1, 11, 3, 0, model[11], bitm(1) | bitm(40), 1'b0);
    access(1'b1, 11, 2, 4, 64'hDEADBEEF_00000000, '0, 1'b0);
    check_eq("R9 write err", CW'({err_q, irq_q}), CW'(3));
    check_eq("R12 narrow cap", CW'({cap_valid, cap_addr, cap_size, cap_write}),
             CW'({1'b1, 4'd11, 2'd2, 1'b1}));
    chk_en = 1'b0;
    access(1'b0, 11, 3, 0, '0, '0, 1'b0);
    check_eq("R9 memory unchanged", CW'(rd_q), CW'(model[11] ^ 64'h0000_0100_0000_0002));
    chk_en = 1'b1;

    // R11: checking off gives raw data and no reporting
    clear_cap();
    model[12] = pat(1212);
    access(1'b1, 12, 3, 0, model[12], bitm(7), 1'b0);
    chk_en = 1'b0;
    access(1'b0, 12, 3, 0, '0, '0, 1'b0);
    check_eq("R11 raw single", CW'(rd_q), CW'(model[12] ^ 64'h80));
    check_eq("R11 no err single", CW'({err_q, irq_q}), CW'(0));
    access(1'b0, 11, 3, 0, '0, '0, 1'b0);
    check_eq("R11 no err double", CW'({err_q, irq_q}), CW'(0));
    check_eq("R11 no capture", CW'(cap_valid), CW'(0));
    chk_en = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", check_cnt, fail_cnt);
    $finish;
  end

endmodule